// File: doc/BRIEF.md
# Four-Entry Data Translation Cache with Tree Pseudo-LRU Refill

This block is a tiny fully associative translation cache that sits between the data address path and a larger shared translation table, here called the backing TLB. Because it is small and close to the load/store path, data address translation runs in parallel with instruction translation. The block holds four translations. Each one maps a single 4KB page from a virtual page number and address-space identifier (ASID) to a physical frame number.

A lookup that hits returns the frame in the next cycle. A lookup that misses raises a stall and sends a refill request to the backing TLB. The block then waits for the response and writes the returned translation into a victim entry. The victim comes from a two-level pseudo-LRU tree. If the backing TLB reports that it has no translation either, nothing is written and a fault goes back to the requester.

A flush input clears every entry in one cycle. It is pulsed whenever the backing TLB is rewritten. Software never sees or addresses the entries.

Top module: `utlb_data`

## Requirements
- R1: After reset all entries are invalid and `stall`, `rf_req`, `res_valid`, `res_hit` and `res_fault` are 0. The tree state is 000, so the first victim is entry 0.
- R2: A lookup accepted with `stall`=0 whose VPN and ASID match a valid entry produces `res_valid`=1, `res_hit`=1, `res_fault`=0 and that entry's frame on `res_pfn` one cycle later. No refill is requested.
- R3: An accepted lookup that does not hit sets `stall`=1 and `rf_req`=1 one cycle later, with the lookup's VPN and ASID on `rf_vpn`/`rf_asid`, and `res_valid`=0. These values are held unchanged until the cycle in which `rf_ack` is seen.
- R4: While `stall`=1, `lk_valid` is ignored. No result is produced and the pending request does not change.
- R5: A response with `rf_ack`=1 and `rf_found`=1 writes the translation into the victim entry. One cycle later it gives `res_valid`=1, `res_hit`=0, `res_fault`=0 and `res_pfn`=`rf_pfn`, with `stall` and `rf_req` back at 0.
- R6: A response with `rf_found`=0 writes nothing and gives `res_valid`=1 with `res_fault`=1 one cycle later. The stall is released.
- R7: The tree state has three bits: `top`, `lo` and `hi`. When `top`=0 the victim is entry 0 if `lo`=0, or entry 1 if `lo`=1. When `top`=1 the victim is entry 2 if `hi`=0, or entry 3 if `hi`=1.
- R8: Every hit and every refill write to entry w sets `top` to the inverse of w[1]. It also sets the bit of w's pair to the inverse of w[0]. The tree then points away from w.
- R9: `flush`=1 invalidates all entries at the next edge, so later lookups miss. A lookup accepted in the same cycle as a flush is treated as a miss. The tree state is not changed by a flush.
- R10: If `flush` coincides with `rf_ack`, the returned translation is not written. The response is still delivered to the requester as in R5/R6.
- R11: An entry matches only when both VPN and ASID are equal. The same VPN under another ASID misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| stall | output | 1 | Refill outstanding, lookups not accepted |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Result served from the local entries |
| res_fault | output | 1 | Backing TLB had no translation |
| res_pfn | output | PFN_W | Physical frame number of the result |
| rf_req | output | 1 | Refill request to the backing TLB |
| rf_vpn | output | VPN_W | Refill VPN |
| rf_asid | output | ASID_W | Refill ASID |
| rf_ack | input | 1 | Refill response strobe |
| rf_found | input | 1 | Backing TLB holds the translation |
| rf_pfn | input | PFN_W | Returned physical frame number |

## Verification
A flush can land in the same cycle as an accepted lookup, or in the same cycle as the refill response. In both cases flush must win: the lookup becomes a miss, and the refill data is discarded while the response is still returned. The random stream pulses `flush` together with lookups and together with `rf_ack` at a fixed rate. A bench reference model applies the same priority rules and also tracks the tree, so each of these cycles is judged by the later hit or miss of the affected page.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);

  typedef enum logic {CTL_IDLE = 1'b0, CTL_WAIT = 1'b1} ctl_state_e;

  // top: 0 -> pair {0,1} is older, lo/hi: older entry inside each pair
  typedef struct packed {
    logic top;
    logic lo;
    logic hi;
  } plru_t;

  function automatic logic [WAY_W-1:0] plru_pick(plru_t s);
    plru_pick = s.top ? {1'b1, s.hi} : {1'b0, s.lo};
  endfunction

  function automatic plru_t plru_touch(plru_t s, logic [WAY_W-1:0] w);
    plru_t n;
    n = s;
    n.top = ~w[1];
    if (w[1]) n.hi = ~w[0];
    else      n.lo = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/utlb_plru.sv
module utlb_plru
  import utlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  plru_t state_q;

  always_ff @(posedge clk) begin
    if (rst)           state_q <= '0;
    else if (touch_en) state_q <= plru_touch(state_q, touch_way);
  end

  assign victim = plru_pick(state_q);

  AST_PLRU_AWAY: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> victim[1] != $past(touch_way[1])); // R8

  AST_PLRU_RESET: assert property (@(posedge clk)
    $past(rst) |-> victim == '0); // R1
endmodule

// File: rtl/utlb_entries.sv
module utlb_entries
  import utlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [VPN_W-1:0]  cmp_vpn,
  input  logic [ASID_W-1:0] cmp_asid,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  input  logic              rd_en,
  output logic [PFN_W-1:0]  rd_pfn,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn
);
  logic [NUM_WAYS-1:0] vld_q;
  logic [VPN_W-1:0]    vpn_q  [NUM_WAYS];
  logic [ASID_W-1:0]   asid_q [NUM_WAYS];
  logic [PFN_W-1:0]    pfn_mem[NUM_WAYS];
  logic [NUM_WAYS-1:0] match;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (vpn_q[g] == cmp_vpn) && (asid_q[g] == cmp_asid);

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(g)) begin
        vpn_q[g]  <= wr_vpn;
        asid_q[g] <= wr_asid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) vld_q <= '0;
    else if (wr_en)   vld_q[wr_way] <= 1'b1;
  end

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (match[i]) hit_way = WAY_W'(i);
  end
  assign hit = |match;

  // frame storage: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (wr_en) pfn_mem[wr_way] <= wr_pfn;
    if (rd_en) rd_pfn <= pfn_mem[hit_way];
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> vld_q == '0); // R9

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en && !flush |=> vld_q[$past(wr_way)]); // R5
endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [WAY_W-1:0]  victim,
  input  logic              rf_ack,
  input  logic              rf_found,
  input  logic [PFN_W-1:0]  rf_pfn,
  output logic              stall,
  output logic              rf_req,
  output logic [VPN_W-1:0]  rf_vpn,
  output logic [ASID_W-1:0] rf_asid,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_fault,
  output logic [PFN_W-1:0]  refill_pfn,
  output logic              rd_en,
  output logic              wr_en,
  output logic [WAY_W-1:0]  wr_way,
  output logic              touch_en,
  output logic [WAY_W-1:0]  touch_way
);
  ctl_state_e state_q;
  logic accept, hit_now, miss_now, ack_now;

  assign accept   = (state_q == CTL_IDLE) && lk_valid;
  assign hit_now  = accept && hit && !flush;
  assign miss_now = accept && !(hit && !flush);
  assign ack_now  = (state_q == CTL_WAIT) && rf_ack;

  assign rd_en     = hit_now;
  assign wr_en     = ack_now && rf_found && !flush;
  assign wr_way    = victim;
  assign touch_en  = hit_now || wr_en;
  assign touch_way = hit_now ? hit_way : victim;

  assign stall  = (state_q == CTL_WAIT);
  assign rf_req = (state_q == CTL_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CTL_IDLE;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= hit_now || ack_now;
      res_hit   <= hit_now;
      res_fault <= ack_now && !rf_found;
      case (state_q)
        CTL_IDLE: if (miss_now) state_q <= CTL_WAIT;
        CTL_WAIT: if (rf_ack)   state_q <= CTL_IDLE;
        default:                state_q <= CTL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (miss_now) begin
      rf_vpn  <= lk_vpn;
      rf_asid <= lk_asid;
    end
    if (ack_now) refill_pfn <= rf_pfn;
  end

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !stall && !(hit && !flush) |=> stall && rf_req); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rf_req && !rf_ack |=> rf_req && $stable(rf_vpn) && $stable(rf_asid)); // R3

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    stall && !rf_ack |=> !res_valid); // R4

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rf_req && rf_ack |=> !stall && res_valid && !res_hit); // R5

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> res_valid && !res_hit); // R6
endmodule

// File: rtl/utlb_data.sv
module utlb_data
  import utlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              stall,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_fault,
  output logic [PFN_W-1:0]  res_pfn,
  output logic              rf_req,
  output logic [VPN_W-1:0]  rf_vpn,
  output logic [ASID_W-1:0] rf_asid,
  input  logic              rf_ack,
  input  logic              rf_found,
  input  logic [PFN_W-1:0]  rf_pfn
);
  logic             hit, rd_en, wr_en, touch_en;
  logic [WAY_W-1:0] hit_way, victim, wr_way, touch_way;
  logic [PFN_W-1:0] rd_pfn, refill_pfn;

  utlb_entries #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_entries (
    .clk(clk), .rst(rst), .flush(flush),
    .cmp_vpn(lk_vpn), .cmp_asid(lk_asid),
    .hit(hit), .hit_way(hit_way),
    .rd_en(rd_en), .rd_pfn(rd_pfn),
    .wr_en(wr_en), .wr_way(wr_way),
    .wr_vpn(rf_vpn), .wr_asid(rf_asid), .wr_pfn(rf_pfn)
  );

  utlb_plru u_plru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_way(touch_way),
    .victim(victim)
  );

  utlb_ctrl #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .hit(hit), .hit_way(hit_way), .victim(victim),
    .rf_ack(rf_ack), .rf_found(rf_found), .rf_pfn(rf_pfn),
    .stall(stall), .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
    .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
    .refill_pfn(refill_pfn),
    .rd_en(rd_en), .wr_en(wr_en), .wr_way(wr_way),
    .touch_en(touch_en), .touch_way(touch_way)
  );

  assign res_pfn = res_hit ? rd_pfn : refill_pfn;
endmodule

// File: tb/utlb_data_bench.sv
module utlb_data_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 20, AW = 8, PW = 24;

  logic clk = 0, rst = 1, flush = 0, lk_valid = 0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic stall, res_valid, res_hit, res_fault, rf_req;
  logic [PW-1:0] res_pfn;
  logic [VW-1:0] rf_vpn;
  logic [AW-1:0] rf_asid;
  logic rf_ack = 0, rf_found = 0;
  logic [PW-1:0] rf_pfn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utlb_data #(.VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) u_utlb_data (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .stall(stall), .res_valid(res_valid), .res_hit(res_hit),
    .res_fault(res_fault), .res_pfn(res_pfn), .rf_req(rf_req), .rf_vpn(rf_vpn),
    .rf_asid(rf_asid), .rf_ack(rf_ack), .rf_found(rf_found), .rf_pfn(rf_pfn)
  );

  int n_chk = 0, n_err = 0;
  logic          m_vld [4];
  logic [VW-1:0] m_vpn [4];
  logic [AW-1:0] m_asid[4];
  logic [PW-1:0] m_pfn [4];
  logic m_top = 0, m_lo = 0, m_hi = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic jt_found(logic [VW-1:0] v);
    return v[3:0] != 4'hF;
  endfunction
  function automatic logic [PW-1:0] jt_pfn(logic [VW-1:0] v, logic [AW-1:0] a);
    return {v ^ 20'h5A5A5, a[3:0]};
  endfunction

  function automatic int m_pick();
    return m_top ? (2 + int'(m_hi)) : int'(m_lo);
  endfunction
  task automatic m_touch(int w);
    m_top = (w < 2);
    if (w >= 2) m_hi = (w == 2); else m_lo = (w == 0);
  endtask
  task automatic m_clear();
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
  endtask

  // one lookup, including refill handshake if it misses
  task automatic lookup(logic [VW-1:0] v, logic [AW-1:0] a, logic fl_lk,
                        logic fl_ack, string req);
    int idx, dly, w;
    logic fnd;
    logic [PW-1:0] p;
    idx = -1;
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_asid = a; flush = fl_lk;
    if (fl_lk) m_clear();
    for (int i = 0; i < 4; i++)
      if (m_vld[i] && m_vpn[i] == v && m_asid[i] == a) idx = i;
    @(negedge clk);
    lk_valid = 0; flush = 0;
    if (idx >= 0) begin
      chk({req, " R2 hit"}, {res_valid, res_hit, res_fault, stall}, 4'b1100);
      chk({req, " R2 pfn"}, res_pfn, m_pfn[idx]);
      m_touch(idx);
      return;
    end
    chk({req, " R3 miss"}, {stall, rf_req, res_valid}, 3'b110);
    chk({req, " R3 req"}, {rf_vpn, rf_asid}, {v, a});
    dly = $urandom_range(0, 3);
    for (int k = 0; k < dly; k++) begin
      lk_valid = 1; lk_vpn = VW'($urandom_range(0, 7)) + 20'h100; lk_asid = a;
      @(negedge clk);
      lk_valid = 0;
      chk("R4 ignored", {stall, res_valid, rf_vpn}, {1'b1, 1'b0, v});
    end
    fnd = jt_found(v); p = jt_pfn(v, a);
    rf_ack = 1; rf_found = fnd; rf_pfn = p; flush = fl_ack;
    if (fl_ack) m_clear();
    else if (fnd) begin
      w = m_pick();
      m_vld[w] = 1; m_vpn[w] = v; m_asid[w] = a; m_pfn[w] = p;
      m_touch(w);
    end
    @(negedge clk);
    rf_ack = 0; flush = 0;
    if (fnd) begin
      chk(fl_ack ? "R10 resp" : "R5 resp",
          {res_valid, res_hit, res_fault, stall, rf_req}, 5'b10000);
      chk("R5 pfn", res_pfn, p);
    end else
      chk("R6 fault", {res_valid, res_hit, res_fault, stall, rf_req}, 5'b10100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    int r;
    void'($urandom(32'd1234));
    m_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset", {stall, rf_req, res_valid, res_hit, res_fault}, 5'b0);

    // directed: fill and victim order 0,2,1,3 (R7)
    lookup(20'h100, 8'd1, 0, 0, "R1 first");
    lookup(20'h101, 8'd1, 0, 0, "R7 fill");
    lookup(20'h102, 8'd1, 0, 0, "R7 fill");
    lookup(20'h103, 8'd1, 0, 0, "R7 fill");
    chk("R7 order", {m_vpn[0][3:0], m_vpn[1][3:0], m_vpn[2][3:0], m_vpn[3][3:0]}, 16'h0213);
    lookup(20'h100, 8'd1, 0, 0, "R8 touch");
    lookup(20'h104, 8'd1, 0, 0, "R7 evict");  // replaces way2 (0x101)
    lookup(20'h101, 8'd1, 0, 0, "R7 victim");  // must miss
    lookup(20'h100, 8'd2, 0, 0, "R11 asid");   // other ASID misses
    lookup(20'h10F, 8'd1, 0, 0, "R6 nojt");
    // flush alone
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0; m_clear();
    chk("R9 flush quiet", {res_valid, stall}, 2'b00);
    lookup(20'h100, 8'd2, 0, 0, "R9 after");
    lookup(20'h100, 8'd2, 1, 0, "R9 same");     // flush with lookup -> miss
    lookup(20'h102, 8'd1, 0, 1, "R10 ackflush");
    lookup(20'h102, 8'd1, 0, 0, "R10 gone");

    for (int n = 0; n < 600; n++) begin
      r = $urandom_range(0, 15);
      v = ($urandom_range(0, 9) == 0) ? 20'h10F : 20'h100 + VW'($urandom_range(0, 5));
      if (r == 0) begin
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0; m_clear();
        chk("R9 flush", res_valid, 1'b0);
      end else
        lookup(v, AW'($urandom_range(1, 2)), r == 1, r == 2, "R8 rand");
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule